// File: doc/BRIEF.md
# Gated Frequency Measurement Counter

This block measures the rate of one of three candidate clock-like signals (an intermediate-frequency signal, a divided prescaler output and a filter-tuning oscillator). The rate is found by counting the selected signal's rising edges during a gate window whose length is a whole number of milliseconds, timed in cycles of the reference clock. A host sets a 2-bit gate code and a 3-bit source code, holds the enable high, and writes a start pulse. The start bit is then set for one cycle and clears itself as the window opens. When the window closes, the edge count is latched into a result that is read as an upper and a lower half. The frequency in kHz is the result divided by the gate time in milliseconds.

The selected signal is brought into the reference domain through a synchronizer chain, and its rising edges are counted there. For this reason, each measured signal must run below half the reference rate. The gate and source codes are captured when a window opens. Later changes to them do not affect the measurement in progress. Dropping the enable aborts a window, and the previous result is kept.

Top module: `freq_gate_counter`

## Requirements
- R1: Gate code 0, 1, 2 and 3 open a window of 4, 8, 32 and 64 ms, where 1 ms is CYC_PER_MS reference cycles. `busy` stays high for exactly that many cycles.
- R2: When `start_wr` is seen while idle with `cnt_en` high, `start_bit` reads 1 in the next cycle. In the cycle after that, it is back to 0, `busy` is 1 and `done` is 0, with no further host write.
- R3: Source codes 1 and 7 count `sig_if`, codes 2 and 3 count `sig_pre`, and codes 4 and 5 count `sig_osc`.
- R4: Source codes 0 and 6 select no signal, and a window taken with them yields a result of 0.
- R5: The result equals the number of rising edges of the selected signal during the window, within two edges. `res_hi` holds the upper BYTE_W bits and `res_lo` holds the lower BYTE_W bits.
- R6: If the window holds more edges than the result can represent, the result is all ones and does not wrap.
- R7: A `start_wr` that arrives while `busy` is high is ignored: `start_bit` stays 0 and the window is not restarted or lengthened.
- R8: With `cnt_en` low, `start_wr` is ignored. Clearing `cnt_en` during a window drops `busy` in the next cycle, leaves `done` at 0 and leaves the result unchanged.
- R9: `done` rises when a window completes and holds until the next window opens. `busy` and `done` are never both high. The result changes only as a window completes.
- R10: The source and gate codes are captured when a window opens. Changing them while `busy` is high affects neither the window length nor the signal counted.
- R11: After reset, `start_bit`, `busy` and `done` are 0 and the result is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Reference clock |
| rst | input | 1 | Synchronous active-high reset |
| cnt_en | input | 1 | Counter enable; must be high for a window to open and run |
| src_sel | input | 3 | Source code (1,7 IF; 2,3 prescaler; 4,5 tuning oscillator; 0,6 none) |
| gate_sel | input | 2 | Gate code (0:4 ms, 1:8 ms, 2:32 ms, 3:64 ms) |
| start_wr | input | 1 | Host write of 1 to the start bit |
| sig_if | input | 1 | Intermediate-frequency signal to measure |
| sig_pre | input | 1 | Prescaler output to measure |
| sig_osc | input | 1 | Filter-tuning oscillator to measure |
| start_bit | output | 1 | Start bit readback; clears itself |
| busy | output | 1 | Gate window open |
| done | output | 1 | Last window completed and result valid |
| res_hi | output | BYTE_W | Upper half of the latched count |
| res_lo | output | BYTE_W | Lower half of the latched count |

## Verification
The assertions check, on every cycle, the properties that do not depend on the signals being measured. The start bit always clears one cycle after it is set. A start is never taken while busy. Busy and done are never high together. A low enable always closes the window. The result moves only as a window ends. Every completed window has one of the four legal lengths. Only the bench scenarios can show that the right source is counted for each of the eight codes, that the counts match the arithmetic expectation, that a count saturates, and that codes changed mid-window are ignored. The bench drives three synchronous test signals of known period and sweeps every source code against every gate code.

// File: rtl/fgc_pkg.sv
package fgc_pkg;

  typedef enum logic [1:0] {
    SRC_NONE = 2'd0,
    SRC_IF   = 2'd1,
    SRC_PRE  = 2'd2,
    SRC_OSC  = 2'd3
  } src_t;

  // Several codes alias onto the same physical source.
  function automatic src_t decode_src(input logic [2:0] code);
    case (code)
      3'd1, 3'd7: decode_src = SRC_IF;
      3'd2, 3'd3: decode_src = SRC_PRE;
      3'd4, 3'd5: decode_src = SRC_OSC;
      default:    decode_src = SRC_NONE;
    endcase
  endfunction

  // Gate length in milliseconds per 2-bit code.
  function automatic int unsigned gate_ms(input logic [1:0] code);
    case (code)
      2'd0:    gate_ms = 4;
      2'd1:    gate_ms = 8;
      2'd2:    gate_ms = 32;
      default: gate_ms = 64;
    endcase
  endfunction

endpackage

// File: rtl/fgc_src_select.sv
module fgc_src_select #(
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       load,
  input  logic [2:0] src_code,
  input  logic       sig_if,
  input  logic       sig_pre,
  input  logic       sig_osc,
  output logic       rise
);
  import fgc_pkg::*;

  localparam int CHAIN = SYNC_STAGES + 1;

  src_t          src_q;
  logic          picked;
  logic [CHAIN-1:0] chain_q;
  logic          rise_q;

  // source captured when a window opens
  always_ff @(posedge clk) begin
    if (rst)       src_q <= SRC_NONE;
    else if (load) src_q <= decode_src(src_code);
  end

  always_comb begin
    case (src_q)
      SRC_IF:  picked = sig_if;
      SRC_PRE: picked = sig_pre;
      SRC_OSC: picked = sig_osc;
      default: picked = 1'b0;
    endcase
  end

  // synchronizer stages plus one history stage for edge detection
  genvar g;
  generate
    for (g = 0; g < CHAIN; g++) begin : g_stage
      if (g == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (rst) chain_q[0] <= 1'b0;
          else     chain_q[0] <= picked;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (rst) chain_q[g] <= 1'b0;
          else     chain_q[g] <= chain_q[g-1];
        end
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) rise_q <= 1'b0;
    else     rise_q <= chain_q[CHAIN-2] & ~chain_q[CHAIN-1];
  end

  assign rise = rise_q;

endmodule

// File: rtl/fgc_gate_timer.sv
module fgc_gate_timer #(
  parameter int CYC_PER_MS = 50000
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       load,
  input  logic [1:0] gate_code,
  input  logic       run,
  output logic       last
);
  import fgc_pkg::*;

  localparam int MAX_CYC = 64 * CYC_PER_MS;
  localparam int TW      = $clog2(MAX_CYC + 1);

  logic [TW-1:0] term_q;
  logic [TW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      term_q <= '0;
      cnt_q  <= '0;
    end else if (load) begin
      term_q <= TW'(gate_ms(gate_code) * CYC_PER_MS - 1);
      cnt_q  <= '0;
    end else if (run) begin
      cnt_q  <= cnt_q + 1'b1;
    end
  end

  assign last = run && (cnt_q == term_q);

endmodule

// File: rtl/fgc_accum.sv
module fgc_accum #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clear,
  input  logic             inc,
  output logic [CNT_W-1:0] value
);
  logic [CNT_W-1:0] acc_q;

  // saturating edge accumulator
  always_ff @(posedge clk) begin
    if (rst)                       acc_q <= '0;
    else if (clear)                acc_q <= '0;
    else if (inc && (acc_q != '1)) acc_q <= acc_q + 1'b1;
  end

  assign value = acc_q;

endmodule

// File: rtl/freq_gate_counter.sv
module freq_gate_counter #(
  parameter int CYC_PER_MS  = 50000,
  parameter int BYTE_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cnt_en,
  input  logic [2:0]        src_sel,
  input  logic [1:0]        gate_sel,
  input  logic              start_wr,
  input  logic              sig_if,
  input  logic              sig_pre,
  input  logic              sig_osc,
  output logic              start_bit,
  output logic              busy,
  output logic              done,
  output logic [BYTE_W-1:0] res_hi,
  output logic [BYTE_W-1:0] res_lo
);
  localparam int CNT_W = 2 * BYTE_W;

  logic             start_q, busy_q, done_q;
  logic [CNT_W-1:0] res_q;
  logic             launch, last, rise, close;
  logic [CNT_W-1:0] acc;

  assign launch = start_q && cnt_en;
  assign close  = busy_q && cnt_en && last;

  fgc_src_select #(.SYNC_STAGES(SYNC_STAGES)) u_src (
    .clk(clk), .rst(rst), .load(launch), .src_code(src_sel),
    .sig_if(sig_if), .sig_pre(sig_pre), .sig_osc(sig_osc), .rise(rise)
  );

  fgc_gate_timer #(.CYC_PER_MS(CYC_PER_MS)) u_gate (
    .clk(clk), .rst(rst), .load(launch), .gate_code(gate_sel),
    .run(busy_q), .last(last)
  );

  fgc_accum #(.CNT_W(CNT_W)) u_acc (
    .clk(clk), .rst(rst), .clear(launch), .inc(rise && busy_q), .value(acc)
  );

  // start bit: set by a host write when idle and enabled, cleared next cycle
  always_ff @(posedge clk) begin
    if (rst)                                start_q <= 1'b0;
    else if (start_q)                       start_q <= 1'b0;
    else if (start_wr && !busy_q && cnt_en) start_q <= 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_q <= 1'b0;
      done_q <= 1'b0;
      res_q  <= '0;
    end else if (launch) begin
      busy_q <= 1'b1;
      done_q <= 1'b0;
    end else if (busy_q && !cnt_en) begin
      busy_q <= 1'b0;
    end else if (close) begin
      busy_q <= 1'b0;
      done_q <= 1'b1;
      res_q  <= acc;
    end
  end

  assign start_bit = start_q;
  assign busy      = busy_q;
  assign done      = done_q;
  assign res_hi    = res_q[CNT_W-1:BYTE_W];
  assign res_lo    = res_q[BYTE_W-1:0];

endmodule

// File: rtl/fgc_checker.sv
module fgc_checker #(
  parameter int CYC_PER_MS = 50000,
  parameter int BYTE_W     = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              cnt_en,
  input logic              start_wr,
  input logic              start_bit,
  input logic              busy,
  input logic              done,
  input logic [BYTE_W-1:0] res_hi,
  input logic [BYTE_W-1:0] res_lo
);
  int unsigned blen;

  always_ff @(posedge clk) begin
    if (rst)       blen <= 0;
    else if (busy) blen <= blen + 1;
    else           blen <= 0;
  end

  a_r2_start_self_clears: assert property (@(posedge clk) disable iff (rst)
    start_bit |=> !start_bit);

  a_r7_no_start_when_busy: assert property (@(posedge clk) disable iff (rst)
    (busy && start_wr) |=> !start_bit);

  a_r8_disable_closes: assert property (@(posedge clk) disable iff (rst)
    !cnt_en |=> !busy);

  a_r9_busy_done_exclusive: assert property (@(posedge clk) disable iff (rst)
    !(busy && done));

  a_r9_result_moves_at_close: assert property (@(posedge clk) disable iff (rst)
    !$stable({res_hi, res_lo}) |-> ($past(busy) && done));

  a_r1_window_length: assert property (@(posedge clk) disable iff (rst)
    ($fell(busy) && done) |->
      (blen == 4 * CYC_PER_MS || blen == 8 * CYC_PER_MS ||
       blen == 32 * CYC_PER_MS || blen == 64 * CYC_PER_MS));

endmodule

bind freq_gate_counter fgc_checker #(.CYC_PER_MS(CYC_PER_MS), .BYTE_W(BYTE_W)) u_fgc_chk (
  .clk(clk), .rst(rst), .cnt_en(cnt_en), .start_wr(start_wr),
  .start_bit(start_bit), .busy(busy), .done(done),
  .res_hi(res_hi), .res_lo(res_lo)
);

// File: tb/test_freq_gate_counter.sv
module test_freq_gate_counter;
  localparam int CPM    = 20;
  localparam int BW     = 4;
  localparam int SATV   = (1 << (2 * BW)) - 1;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cnt_en = 1'b0, start_wr = 1'b0;
  logic [2:0] src_sel = 3'd0;
  logic [1:0] gate_sel = 2'd0;
  logic sig_if = 1'b0, sig_pre = 1'b0, sig_osc = 1'b0;
  logic start_bit, busy, done;
  logic [BW-1:0] res_hi, res_lo;

  int tests = 0, fails = 0;
  bit finished = 0;

  freq_gate_counter #(.CYC_PER_MS(CPM), .BYTE_W(BW), .SYNC_STAGES(2)) i_freq_gate_counter (
    .clk(clk), .rst(rst), .cnt_en(cnt_en), .src_sel(src_sel), .gate_sel(gate_sel),
    .start_wr(start_wr), .sig_if(sig_if), .sig_pre(sig_pre), .sig_osc(sig_osc),
    .start_bit(start_bit), .busy(busy), .done(done), .res_hi(res_hi), .res_lo(res_lo)
  );

  always #10 clk = ~clk;

  // measured signals: periods of 2, 6 and 10 reference cycles
  int ph_pre = 0, ph_osc = 0;
  always @(negedge clk) begin
    sig_if <= ~sig_if;
    ph_pre <= (ph_pre == 2) ? 0 : ph_pre + 1;
    if (ph_pre == 2) sig_pre <= ~sig_pre;
    ph_osc <= (ph_osc == 4) ? 0 : ph_osc + 1;
    if (ph_osc == 4) sig_osc <= ~sig_osc;
  end

  function automatic int period_of(input int code);
    case (code)
      1, 7: return 2;
      2, 3: return 6;
      4, 5: return 10;
      default: return 0;
    endcase
  endfunction

  function automatic int win_of(input int g);
    case (g)
      0: return 4 * CPM;
      1: return 8 * CPM;
      2: return 32 * CPM;
      default: return 64 * CPM;
    endcase
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int result();
    return int'({res_hi, res_lo});
  endfunction

  // launch a window; returns the number of busy cycles observed
  task automatic launch(input int s, input int g, input int mid_src, input int mid_gate,
                        input bit poke_start, output int blen);
    @(negedge clk);
    src_sel = 3'(s); gate_sel = 2'(g); start_wr = 1'b1;
    @(negedge clk);
    start_wr = 1'b0;
    chk(start_bit == 1'b1, "R2 start bit set", int'(start_bit), 1);
    @(negedge clk);
    chk(start_bit == 1'b0 && busy == 1'b1 && done == 1'b0, "R2 self clear, busy",
        int'({start_bit, busy, done}), 3'b010);
    blen = 0;
    while (busy && blen < 5000) begin
      blen++;
      if (blen == 10 && mid_src >= 0) begin
        src_sel = 3'(mid_src); gate_sel = 2'(mid_gate);
      end
      if (blen == 12 && poke_start) start_wr = 1'b1;
      if (blen == 13 && poke_start) begin
        start_wr = 1'b0;
        chk(start_bit == 1'b0, "R7 start ignored while busy", int'(start_bit), 0);
      end
      @(negedge clk);
    end
  endtask

  task automatic check_count(input int s, input int g, input string tag);
    int per, exp, act;
    per = period_of(s);
    act = result();
    if (per == 0) begin
      chk(act == 0, {tag, " R4 unused source"}, act, 0);
    end else begin
      exp = win_of(g) / per;
      if (exp >= SATV + 3)
        chk(act == SATV, {tag, " R6 saturation"}, act, SATV);
      else
        chk(act <= SATV && act >= exp - 2 && act <= exp + 2, {tag, " R3/R5 count"}, act, exp);
    end
  endtask

  initial begin
    #(20 * 150000);
    if (!finished) begin
      tests++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    int bl, prev;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R11: reset state
    chk(start_bit == 0 && busy == 0 && done == 0 && result() == 0, "R11 reset state",
        int'({start_bit, busy, done}) + result(), 0);

    // R8: start ignored with enable low
    @(negedge clk); start_wr = 1'b1;
    @(negedge clk); start_wr = 1'b0;
    chk(start_bit == 0, "R8 start with enable low", int'(start_bit), 0);
    @(negedge clk);
    chk(busy == 0, "R8 no window with enable low", int'(busy), 0);

    cnt_en = 1'b1;
    // sweep every source code against every gate code (R1, R3, R4, R5, R6, R9)
    for (int s = 0; s < 8; s++) begin
      for (int g = 0; g < 4; g++) begin
        launch(s, g, -1, 0, 1'b0, bl);
        chk(bl == win_of(g), "R1 window length", bl, win_of(g));
        chk(done == 1 && busy == 0, "R9 done after window", int'({busy, done}), 1);
        check_count(s, g, "sweep");
        repeat (3) @(negedge clk);
        chk(done == 1, "R9 done holds while idle", int'(done), 1);
      end
    end

    // R7: start during a window does not restart it
    launch(4, 0, -1, 0, 1'b1, bl);
    chk(bl == win_of(0), "R7 window not lengthened", bl, win_of(0));
    check_count(4, 0, "R7");

    // R10: codes changed mid-window are ignored
    launch(1, 0, 0, 3, 1'b0, bl);
    chk(bl == win_of(0), "R10 gate captured", bl, win_of(0));
    check_count(1, 0, "R10 source captured");

    // R8: abort by clearing enable
    prev = result();
    launch(5, 3, -1, 0, 1'b0, bl);  // completes; prev for abort taken below
    prev = result();
    @(negedge clk);
    src_sel = 3'd2; gate_sel = 2'd3; start_wr = 1'b1;
    @(negedge clk); start_wr = 1'b0;
    @(negedge clk);
    chk(busy == 1 && done == 0, "R9 done cleared at launch", int'({busy, done}), 2);
    repeat (20) @(negedge clk);
    cnt_en = 1'b0;
    @(negedge clk);
    chk(busy == 0, "R8 abort drops busy", int'(busy), 0);
    chk(done == 0, "R8 abort leaves done low", int'(done), 0);
    chk(result() == prev, "R8 abort keeps result", result(), prev);
    repeat (5) @(negedge clk);
    chk(result() == prev, "R8 result still kept", result(), prev);

    finished = 1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule